// File: doc/BRIEF.md
# Range Invalidation Chunk Sequencer

This block turns one request to invalidate a data-cache address range into a series of commands for a purge unit that matches tags under a mask. It does not walk the range one cache line at a time. Each command covers one naturally aligned power-of-two chunk, and that chunk is as large as two limits allow: the alignment of the current start address and the number of bytes still left.

For each chunk the block writes a mask word and then a command word. Between commands it waits on the purge unit's busy flag. A request comes in one of three forms: a start and an end address, a start and a byte count, or the page that holds a given address.

In write-back mode, a range whose start or end is not line aligned cannot be invalidated safely, so the block hands the request to the flush-and-invalidate path instead. In write-through mode it rounds the range out to whole lines. A lock output stays high while a request is in progress, so that no other requester can interleave purge commands. A one-cycle done pulse marks the end of every request.

Top module: `rinv_chunk_seq`

## Requirements
- R1: `req_form` selects how the range is built. Value 0 means `req_start` to end address `req_arg`. Value 1 means end = `req_start` + `req_arg`. Value 2 means the start is `req_start` rounded down to a page boundary (4096 bytes) and the end is that start plus one page. Value 3 behaves like 0.
- R2: When `cache_en` is low at acceptance and the request is not diverted, no mask write and no command write occur, and `done` still pulses with `flush_divert` low.
- R3: When `wb_mode` is high and either the range start or the range end is not a multiple of the line size (16 bytes), `done` pulses together with `flush_divert`, and no mask or command write occurs. This holds even when `cache_en` is low.
- R4: Outside the case in R3, the start is rounded down and the end rounded up to a multiple of the line size before chunking.
- R5: No mask write occurs until `purge_busy` has been seen low. This applies both after acceptance and after each command.
- R6: Each chunk is a power of two. When the current start is zero, the chunk is the largest power of two not above the remaining bytes. Otherwise it is the lowest set bit of the start if the remaining bytes exceed that bit, and the largest power of two not above the remaining bytes if they do not.
- R7: Each chunk writes `mask_data` = NOT(chunk-1) with `mask_we`, and in the next cycle writes `cmd_data` = current start OR bit 0 (the invalidate bit) with `cmd_we`.
- R8: After each command, the start advances by the chunk and the remaining size shrinks by the chunk. Commands continue while the start is below the end. A rounded range with end at or below start issues no command.
- R9: `lock` is high from the cycle after the accepting edge through the `done` cycle, and low otherwise. While `lock` is high, `req_valid` is ignored.
- R10: `done` is a one-cycle pulse. For a request that issues no command, `done` is high in the second cycle after the cycle in which `req_valid` was driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, sampled only while `lock` is low |
| req_form | input | 2 | Request form (0 start/end, 1 start/size, 2 page, 3 as 0) |
| req_start | input | 32 | Start address |
| req_arg | input | 32 | End address (form 0 and 3) or byte count (form 1) |
| cache_en | input | 1 | Data cache enabled |
| wb_mode | input | 1 | Write-back mode |
| purge_busy | input | 1 | Purge unit busy |
| mask_we | output | 1 | Mask register write strobe |
| mask_data | output | 32 | Mask register value |
| cmd_we | output | 1 | Command register write strobe |
| cmd_data | output | 32 | Command register value |
| flush_divert | output | 1 | Request handed to the flush-and-invalidate path |
| done | output | 1 | Request complete (one cycle) |
| lock | output | 1 | Sequence in progress |

## Verification
A request that issues no command (disabled cache, diversion or empty range) has its `done` due exactly two cycles after the request is driven, and the bench checks that exact cycle count. A chunked request has no fixed length, because the purge model holds busy for a random 1 to 4 cycles after every command. For those requests the bench therefore collects every mask and command write as it appears and compares the whole list with its own model when `done` arrives. Each mask write must come exactly one cycle before its command write and only while busy is low. All outputs are sampled on the falling edge, and one cycle after `done` the bench confirms that `lock` has dropped and that no further writes follow.

// File: rtl/rinv_pkg.sv
package rinv_pkg;

   typedef enum logic [1:0] {
      FORM_SPAN  = 2'd0,
      FORM_COUNT = 2'd1,
      FORM_PAGE  = 2'd2,
      FORM_ALT   = 2'd3
   } req_form_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_PREP,
      ST_DRAIN,
      ST_MASK,
      ST_CMD,
      ST_WAIT,
      ST_DONE
   } seq_state_e;

endpackage

// File: rtl/rinv_req_norm.sv
// Builds the line-rounded range from one request and flags a line-misaligned
// raw range (used to divert in write-back mode).
module rinv_req_norm #(
   parameter int ADDR_W    = 32,
   parameter int LINE_LOG2 = 4,
   parameter int PAGE_LOG2 = 12
) (
   input  logic [1:0]        form_i,
   input  logic [ADDR_W-1:0] start_i,
   input  logic [ADDR_W-1:0] arg_i,
   output logic [ADDR_W-1:0] base_o,
   output logic [ADDR_W-1:0] limit_o,
   output logic              unaligned_o
);
   import rinv_pkg::*;

   localparam logic [ADDR_W-1:0] LINE_BYTES = ADDR_W'(1) << LINE_LOG2;
   localparam logic [ADDR_W-1:0] LINE_MASK  = LINE_BYTES - ADDR_W'(1);
   localparam logic [ADDR_W-1:0] PAGE_BYTES = ADDR_W'(1) << PAGE_LOG2;
   localparam logic [ADDR_W-1:0] PAGE_MASK  = PAGE_BYTES - ADDR_W'(1);

   logic [ADDR_W-1:0] raw_base;
   logic [ADDR_W-1:0] raw_limit;

   always_comb begin
      raw_base  = start_i;
      raw_limit = arg_i;
      case (req_form_e'(form_i))
         FORM_COUNT: raw_limit = start_i + arg_i;
         FORM_PAGE: begin
            raw_base  = start_i & ~PAGE_MASK;
            raw_limit = (start_i & ~PAGE_MASK) + PAGE_BYTES;
         end
         default: raw_limit = arg_i;
      endcase
   end

   assign unaligned_o = ((raw_base & LINE_MASK) != '0) || ((raw_limit & LINE_MASK) != '0);
   assign base_o      = raw_base & ~LINE_MASK;
   assign limit_o     = (raw_limit + LINE_MASK) & ~LINE_MASK;

endmodule

// File: rtl/rinv_chunk_calc.sv
// Picks the largest aligned power-of-two chunk for the current start and the
// bytes remaining. The start is always line aligned here.
module rinv_chunk_calc #(
   parameter int ADDR_W       = 32,
   parameter bit FAST_ISOLATE = 1'b1
) (
   input  logic [ADDR_W-1:0] base_i,
   input  logic [ADDR_W-1:0] remain_i,
   output logic [ADDR_W-1:0] chunk_o
);

   logic [ADDR_W-1:0] align_hot;
   logic [ADDR_W-1:0] remain_hot;

   generate
      if (FAST_ISOLATE) begin : g_iso_arith
         assign align_hot = base_i & (~base_i + ADDR_W'(1));
      end else begin : g_iso_scan
         always_comb begin
            logic seen;
            seen      = 1'b0;
            align_hot = '0;
            for (int b = 0; b < ADDR_W; b++) begin
               if (base_i[b] && !seen) begin
                  align_hot[b] = 1'b1;
                  seen         = 1'b1;
               end
            end
         end
      end
   endgenerate

   always_comb begin
      logic seen_hi;
      seen_hi    = 1'b0;
      remain_hot = '0;
      for (int b = ADDR_W - 1; b >= 0; b--) begin
         if (remain_i[b] && !seen_hi) begin
            remain_hot[b] = 1'b1;
            seen_hi       = 1'b1;
         end
      end
   end

   always_comb begin
      if (base_i == '0)
         chunk_o = remain_hot;
      else if (remain_i > align_hot)
         chunk_o = align_hot;
      else
         chunk_o = remain_hot;
   end

endmodule

// File: rtl/rinv_seq_fsm.sv
// Control sequence: capture, screen, drain busy, then mask / command / wait
// per chunk until the start reaches the end.
module rinv_seq_fsm #(
   parameter int ADDR_W  = 32,
   parameter int CMD_BIT = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] norm_base,
   input  logic [ADDR_W-1:0] norm_limit,
   input  logic              norm_unaligned,
   input  logic              cache_en,
   input  logic              wb_mode,
   input  logic              purge_busy,
   input  logic [ADDR_W-1:0] chunk_i,
   output logic [ADDR_W-1:0] base_o,
   output logic [ADDR_W-1:0] remain_o,
   output logic              mask_we,
   output logic [ADDR_W-1:0] mask_data,
   output logic              cmd_we,
   output logic [ADDR_W-1:0] cmd_data,
   output logic              flush_divert,
   output logic              done,
   output logic              lock
);
   import rinv_pkg::*;

   localparam logic [ADDR_W-1:0] CMD_ONE = ADDR_W'(1) << CMD_BIT;

   seq_state_e        state_q, state_d;
   logic [ADDR_W-1:0] base_q, base_d;
   logic [ADDR_W-1:0] limit_q, limit_d;
   logic [ADDR_W-1:0] rem_q, rem_d;
   logic [ADDR_W-1:0] chunk_q, chunk_d;
   logic              unal_q, unal_d;
   logic              en_q, en_d;
   logic              wb_q, wb_d;
   logic              div_q, div_d;
   logic [ADDR_W-1:0] next_base;

   assign next_base = base_q + chunk_q;

   always_comb begin
      state_d = state_q;
      base_d  = base_q;
      limit_d = limit_q;
      rem_d   = rem_q;
      chunk_d = chunk_q;
      unal_d  = unal_q;
      en_d    = en_q;
      wb_d    = wb_q;
      div_d   = div_q;
      case (state_q)
         ST_IDLE: begin
            if (req_valid) begin
               base_d  = norm_base;
               limit_d = norm_limit;
               unal_d  = norm_unaligned;
               en_d    = cache_en;
               wb_d    = wb_mode;
               div_d   = 1'b0;
               state_d = ST_PREP;
            end
         end
         ST_PREP: begin
            rem_d = limit_q - base_q;
            if (wb_q && unal_q) begin
               div_d   = 1'b1;
               state_d = ST_DONE;
            end else if (!en_q || (limit_q <= base_q)) begin
               state_d = ST_DONE;
            end else begin
               state_d = ST_DRAIN;
            end
         end
         ST_DRAIN: begin
            if (!purge_busy) state_d = ST_MASK;
         end
         ST_MASK: begin
            chunk_d = chunk_i;
            state_d = ST_CMD;
         end
         ST_CMD: begin
            state_d = ST_WAIT;
         end
         ST_WAIT: begin
            if (!purge_busy) begin
               base_d  = next_base;
               rem_d   = rem_q - chunk_q;
               state_d = (next_base < limit_q) ? ST_MASK : ST_DONE;
            end
         end
         ST_DONE: begin
            div_d   = 1'b0;
            state_d = ST_IDLE;
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         base_q  <= '0;
         limit_q <= '0;
         rem_q   <= '0;
         chunk_q <= '0;
         unal_q  <= 1'b0;
         en_q    <= 1'b0;
         wb_q    <= 1'b0;
         div_q   <= 1'b0;
      end else begin
         state_q <= state_d;
         base_q  <= base_d;
         limit_q <= limit_d;
         rem_q   <= rem_d;
         chunk_q <= chunk_d;
         unal_q  <= unal_d;
         en_q    <= en_d;
         wb_q    <= wb_d;
         div_q   <= div_d;
      end
   end

   assign base_o       = base_q;
   assign remain_o     = rem_q;
   assign mask_we      = (state_q == ST_MASK);
   assign mask_data    = ~(chunk_i - ADDR_W'(1));
   assign cmd_we       = (state_q == ST_CMD);
   assign cmd_data     = base_q | CMD_ONE;
   assign done         = (state_q == ST_DONE);
   assign flush_divert = (state_q == ST_DONE) && div_q;
   assign lock         = (state_q != ST_IDLE);

endmodule

// File: rtl/rinv_chunk_seq.sv
module rinv_chunk_seq #(
   parameter int ADDR_W       = 32,
   parameter int LINE_LOG2    = 4,
   parameter int PAGE_LOG2    = 12,
   parameter int CMD_BIT      = 0,
   parameter bit FAST_ISOLATE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [1:0]        req_form,
   input  logic [ADDR_W-1:0] req_start,
   input  logic [ADDR_W-1:0] req_arg,
   input  logic              cache_en,
   input  logic              wb_mode,
   input  logic              purge_busy,
   output logic              mask_we,
   output logic [ADDR_W-1:0] mask_data,
   output logic              cmd_we,
   output logic [ADDR_W-1:0] cmd_data,
   output logic              flush_divert,
   output logic              done,
   output logic              lock
);

   generate
      if (LINE_LOG2 < 1 || CMD_BIT < 0 || CMD_BIT >= LINE_LOG2) begin : g_bad_cmd_bit
         $error("invalidate bit must sit below the line offset");
      end
      if (PAGE_LOG2 < LINE_LOG2 || PAGE_LOG2 >= ADDR_W) begin : g_bad_page
         $error("page size must be at least a line and below the address span");
      end
   endgenerate

   logic [ADDR_W-1:0] n_base, n_limit, cur_base, cur_rem, chunk;
   logic              n_unal;

   rinv_req_norm #(
      .ADDR_W(ADDR_W), .LINE_LOG2(LINE_LOG2), .PAGE_LOG2(PAGE_LOG2)
   ) u_norm (
      .form_i(req_form), .start_i(req_start), .arg_i(req_arg),
      .base_o(n_base), .limit_o(n_limit), .unaligned_o(n_unal)
   );

   rinv_chunk_calc #(
      .ADDR_W(ADDR_W), .FAST_ISOLATE(FAST_ISOLATE)
   ) u_calc (
      .base_i(cur_base), .remain_i(cur_rem), .chunk_o(chunk)
   );

   rinv_seq_fsm #(
      .ADDR_W(ADDR_W), .CMD_BIT(CMD_BIT)
   ) u_fsm (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
      .norm_base(n_base), .norm_limit(n_limit), .norm_unaligned(n_unal),
      .cache_en(cache_en), .wb_mode(wb_mode), .purge_busy(purge_busy),
      .chunk_i(chunk), .base_o(cur_base), .remain_o(cur_rem),
      .mask_we(mask_we), .mask_data(mask_data), .cmd_we(cmd_we),
      .cmd_data(cmd_data), .flush_divert(flush_divert), .done(done),
      .lock(lock)
   );

endmodule

// File: rtl/rinv_chunk_seq_chk.sv
module rinv_chunk_seq_chk #(
   parameter int ADDR_W    = 32,
   parameter int LINE_LOG2 = 4,
   parameter int CMD_BIT   = 0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              purge_busy,
   input logic              mask_we,
   input logic [ADDR_W-1:0] mask_data,
   input logic              cmd_we,
   input logic [ADDR_W-1:0] cmd_data,
   input logic              flush_divert,
   input logic              done,
   input logic              lock
);
   localparam logic [ADDR_W-1:0] CMD_ONE = ADDR_W'(1) << CMD_BIT;

   assert_mask_then_cmd_R7: assert property (@(posedge clk) disable iff (!rst_n)
      mask_we |=> cmd_we);

   assert_cmd_has_mask_R7: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_we |-> $past(mask_we));

   assert_chunk_shape_R6: assert property (@(posedge clk) disable iff (!rst_n)
      mask_we |-> (mask_data[LINE_LOG2-1:0] == '0) && $onehot(~mask_data + ADDR_W'(1)));

   assert_cmd_aligned_R7: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_we |-> ((cmd_data & CMD_ONE) != '0) &&
                 ((cmd_data & ~$past(mask_data) & ~CMD_ONE) == '0));

   assert_busy_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
      mask_we |-> !$past(purge_busy));

   assert_lock_cover_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_we || cmd_we || done) |-> lock);

   assert_lock_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(lock) |-> $past(done));

   assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_divert_with_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
      flush_divert |-> done && !cmd_we && !mask_we);

endmodule

bind rinv_chunk_seq rinv_chunk_seq_chk #(
   .ADDR_W(ADDR_W), .LINE_LOG2(LINE_LOG2), .CMD_BIT(CMD_BIT)
) u_chk (
   .clk(clk), .rst_n(rst_n), .purge_busy(purge_busy),
   .mask_we(mask_we), .mask_data(mask_data), .cmd_we(cmd_we),
   .cmd_data(cmd_data), .flush_divert(flush_divert), .done(done),
   .lock(lock)
);

// File: tb/rinv_chunk_seq_test.sv
`timescale 1ns/1ps
module rinv_chunk_seq_test;
   localparam int LL = 4;
   localparam int PL = 12;
   localparam logic [31:0] LM = (32'd1 << LL) - 32'd1;
   localparam logic [31:0] PM = (32'd1 << PL) - 32'd1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0;
   logic [1:0] req_form = 2'd0;
   logic [31:0] req_start = '0, req_arg = '0;
   logic cache_en = 1'b0, wb_mode = 1'b0;
   logic purge_busy;
   logic mask_we, cmd_we, flush_divert, done, lock;
   logic [31:0] mask_data, cmd_data;

   logic hold_busy = 1'b0;
   logic [2:0] busy_cnt;

   int n_cmp = 0, n_bad = 0;
   logic [31:0] exp_mask [64], exp_cmd [64], got_mask [64], got_cmd [64];
   int exp_n, got_n, got_m;
   bit exp_div;

   always #4 clk = ~clk;

   rinv_chunk_seq uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_form(req_form),
      .req_start(req_start), .req_arg(req_arg), .cache_en(cache_en),
      .wb_mode(wb_mode), .purge_busy(purge_busy), .mask_we(mask_we),
      .mask_data(mask_data), .cmd_we(cmd_we), .cmd_data(cmd_data),
      .flush_divert(flush_divert), .done(done), .lock(lock)
   );

   // purge unit model: busy for 1..4 cycles after each command
   assign purge_busy = hold_busy || (busy_cnt != 3'd0);
   always @(posedge clk) begin
      if (!rst_n) busy_cnt <= 3'd0;
      else if (cmd_we) busy_cnt <= 3'd1 + 3'($urandom % 4);
      else if (busy_cnt != 3'd0) busy_cnt <= busy_cnt - 3'd1;
   end

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // write monitor, sampled on the falling edge
   always @(negedge clk) begin
      if (rst_n && mask_we) begin
         chk(!purge_busy, "R5 mask written while busy", 32'(purge_busy), 32'd0);
         chk(lock, "R9 lock during mask write", 32'(lock), 32'd1);
         if (got_m < 64) got_mask[got_m] = mask_data;
         got_m++;
      end
      if (rst_n && cmd_we) begin
         chk(lock, "R9 lock during command", 32'(lock), 32'd1);
         if (got_n < 64) got_cmd[got_n] = cmd_data;
         got_n++;
      end
   end

   function automatic logic [31:0] top_pow(input logic [31:0] v);
      for (int i = 31; i >= 0; i--) if (v[i]) return 32'd1 << i;
      return 32'd0;
   endfunction

   function automatic logic [31:0] low_pow(input logic [31:0] v);
      for (int i = 0; i < 32; i++) if (v[i]) return 32'd1 << i;
      return 32'd0;
   endfunction

   task automatic model(input logic [1:0] f, input logic [31:0] s, input logic [31:0] a,
                        input bit en, input bit wb);
      logic [31:0] rs, re, cs, ce, rem, c, al;
      rs = (f == 2'd2) ? (s & ~PM) : s;
      re = (f == 2'd1) ? s + a : (f == 2'd2) ? rs + PM + 32'd1 : a;
      exp_n = 0;
      exp_div = 1'b0;
      if (wb && (((rs | re) & LM) != 0)) begin
         exp_div = 1'b1;
      end else if (en) begin
         cs = rs & ~LM;
         ce = (re + LM) & ~LM;
         if (ce > cs) begin
            rem = ce - cs;
            while (cs < ce && exp_n < 64) begin
               al = low_pow(cs);
               if (cs == 0) c = top_pow(rem);
               else if (rem > al) c = al;
               else c = top_pow(rem);
               exp_mask[exp_n] = ~(c - 32'd1);
               exp_cmd[exp_n]  = cs | 32'd1;
               exp_n++;
               cs  = cs + c;
               rem = rem - c;
            end
         end
      end
   endtask

   task automatic run_req(input logic [1:0] f, input logic [31:0] s, input logic [31:0] a,
                          input bit en, input bit wb, input int hold, input bit intrude,
                          input string tag);
      int cyc;
      bit div_seen;
      model(f, s, a, en, wb);
      got_n = 0;
      got_m = 0;
      @(negedge clk);
      req_valid = 1'b1; req_form = f; req_start = s; req_arg = a;
      cache_en = en; wb_mode = wb;
      hold_busy = (hold > 0);
      @(negedge clk);
      req_valid = 1'b0;
      req_form = 2'd0; req_start = 32'h0000_5000; req_arg = 32'h0000_9000;
      cyc = 1;
      while (!done && cyc < 4000) begin
         if (hold > 0 && cyc >= hold) hold_busy = 1'b0;
         req_valid = (intrude && (cyc == 6));
         @(negedge clk);
         cyc++;
      end
      req_valid = 1'b0;
      hold_busy = 1'b0;
      div_seen = flush_divert;
      chk(cyc < 4000, {tag, " R10 done never seen"}, 32'(cyc), 32'd0);
      if (exp_n == 0)
         chk(cyc == 2, {tag, " R10 done timing"}, 32'(cyc), 32'd2);
      chk(div_seen == exp_div, {tag, " R3 divert"}, 32'(div_seen), 32'(exp_div));
      chk(got_n == exp_n, {tag, " R8 command count"}, 32'(got_n), 32'(exp_n));
      chk(got_m == exp_n, {tag, " R7 mask count"}, 32'(got_m), 32'(exp_n));
      for (int i = 0; i < exp_n && i < got_n && i < 64; i++) begin
         chk(got_mask[i] == exp_mask[i], {tag, " R6 chunk mask"}, got_mask[i], exp_mask[i]);
         chk(got_cmd[i] == exp_cmd[i], {tag, " R7 command word"}, got_cmd[i], exp_cmd[i]);
      end
      @(negedge clk);
      chk(!done, {tag, " R10 done one cycle"}, 32'(done), 32'd0);
      chk(!lock, {tag, " R9 lock released"}, 32'(lock), 32'd0);
      repeat (2) @(negedge clk);
      chk(got_n == exp_n, {tag, " R9 no stray commands"}, 32'(got_n), 32'(exp_n));
   endtask

   initial begin : watchdog
      repeat (190000) @(posedge clk);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin : stim
      void'($urandom(32'd20240611));
      got_n = 0;
      got_m = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!lock && !done && !mask_we && !cmd_we && !flush_divert, "R9 reset state",
          {27'd0, lock, done, mask_we, cmd_we, flush_divert}, 32'd0);

      // directed corner cases
      run_req(2'd0, 32'h0000_0000, 32'h0000_3000, 1'b1, 1'b0, 0, 1'b0, "R6 zero start");
      run_req(2'd0, 32'h0000_1003, 32'h0000_1011, 1'b1, 1'b0, 0, 1'b0, "R4 round out");
      run_req(2'd2, 32'h0001_2345, 32'hDEAD_BEEF, 1'b1, 1'b0, 0, 1'b0, "R1 page form");
      run_req(2'd1, 32'h0000_0030, 32'h0000_0FD0, 1'b1, 1'b1, 0, 1'b0, "R1 size form");
      run_req(2'd3, 32'h0000_0040, 32'h0000_0100, 1'b1, 1'b1, 0, 1'b0, "R1 alt form");
      run_req(2'd0, 32'h0000_1000, 32'h0000_2000, 1'b0, 1'b0, 0, 1'b0, "R2 cache off");
      run_req(2'd0, 32'h0000_1008, 32'h0000_2000, 1'b1, 1'b1, 0, 1'b0, "R3 wb start");
      run_req(2'd1, 32'h0000_1000, 32'h0000_0024, 1'b0, 1'b1, 0, 1'b0, "R3 wb end cache off");
      run_req(2'd0, 32'h0000_2000, 32'h0000_1000, 1'b1, 1'b0, 0, 1'b0, "R8 empty range");
      run_req(2'd0, 32'h0000_2010, 32'h0000_2010, 1'b1, 1'b1, 0, 1'b0, "R8 zero length");
      run_req(2'd0, 32'h0000_0400, 32'h0000_0800, 1'b1, 1'b0, 7, 1'b0, "R5 busy at start");
      run_req(2'd0, 32'h0000_0010, 32'h0010_0000, 1'b1, 1'b0, 0, 1'b1, "R9 ignored request");
      run_req(2'd1, 32'h8000_0000, 32'h7FFF_FFF0, 1'b1, 1'b1, 2, 1'b0, "R6 top of space");

      // constrained random requests
      for (int k = 0; k < 150; k++) begin
         logic [1:0] f;
         logic [31:0] s, a;
         bit en, wb;
         f  = 2'($urandom % 4);
         s  = $urandom;
         if (($urandom % 3) == 0) s = s & ~LM;
         if (f == 2'd1) a = $urandom % 32'h0004_0000;
         else if (($urandom % 8) == 0) a = s - ($urandom % 32'h100);
         else a = s + ($urandom % 32'h0004_0000);
         if (($urandom % 3) == 0) a = a & ~LM;
         en = (($urandom % 10) != 0);
         wb = (($urandom % 2) == 0);
         run_req(f, s, a, en, wb, int'($urandom % 4), 1'b0, "R6 random");
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule